// File: doc/BRIEF.md
# Dithered Two-Channel PWM Generator

This block drives two PWM pins from a single symmetric counter. The counter climbs from 0 to 255 and falls back again, so every period lasts 512 clocks. Both channels see the same position value, which locks them to one period and one phase. Each channel takes a 15-bit level. The upper eight bits give a coarse compare value. The lower seven bits are a fraction that a first-order delta-sigma accumulator spreads across periods, adding one count to a period's compare value whenever the accumulator overflows.

The compare value for the next period is always worked out one period ahead. At a period boundary, the value prepared earlier is moved into the active compare register, and only then is the following value calculated. Loading a new level does not wait for a boundary. The active and the prepared compare values both take the coarse part at once, which lets fast effects such as strobes respond within a clock.

Top module: `dsm_pwm_top`

## Requirements
- R1: A period is 512 clocks, numbered 0 to 511 from the first rising edge after reset is released. Counter position p is k for k below 256 and 511-k above that. The pin value sampled after edge k is 1 exactly when p is below the active compare value of that channel. With no load, a channel is high for 2*C of the 512 samples of a period, where C is its active compare value.
- R2: Channel i reads its level from bits [15i+14:15i] of the level bus. Bits 14:7 are the coarse compare value and bits 6:0 are the fraction. With a fraction of zero, every period after a load has compare value equal to the coarse part.
- R3: At each period boundary, the fraction is added to a 7-bit accumulator. The value prepared for the next period is the coarse part plus one when the sum exceeds 127. The accumulator then keeps only the low seven bits of the sum.
- R4: The compare value applied at a boundary is the one prepared at the previous boundary, so a carry shows up one period after the accumulation that produced it.
- R5: A load strobe sampled at an edge sets both the active and the prepared compare values to the coarse part of the new level. The pin sample after the next edge already uses the new compare value, even in the middle of a period.
- R6: A load does not clear the accumulator. A load that coincides with a period boundary takes priority over that boundary's update, so no accumulation happens at that boundary.
- R7: A level of zero keeps the pin low for every sample from the clock after the load onward.
- R8: A coarse part of 255 plus a carry gives a compare value of 256, and the pin then stays high for all 512 samples of that period.
- R9: In reset, and during the first period after reset, both pins are low, and accumulators and compare values start at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the counter and all state |
| rst | input | 1 | Synchronous reset, active high |
| loadStb | input | 1 | Load the level bus into both channels at this edge |
| levelIn | input | CH_COUNT*15 | Packed 15-bit levels, channel 0 in the low bits |
| pwmOut | output | CH_COUNT | Registered PWM pins |

## Verification
The hardest case to reach from the pins is a load that lands exactly on the edge that closes a period while the accumulator holds a nonzero remainder. Only then does the skipped accumulation of R6 change how the later carries fall. The stimulus counts edges from the release of reset and places each load on a chosen position within a period. Some loads land on the boundary edge after mid-period loads have left residue in the accumulators. Others land at rising-half and falling-half positions, so the per-period high counts expose both the immediate response and the carry pattern.

// File: rtl/dsm_pwm_pkg.sv
package dsm_pwm_pkg;

  localparam int DEF_PWM_W  = 8;
  localparam int DEF_FRAC_W = 7;
  localparam int DEF_CH     = 2;

  // strobes from the sequencing logic to the channel datapath
  typedef struct packed {
    logic periodEnd;
    logic loadNow;
  } ctlStrobes_t;

endpackage

// File: rtl/dsm_pwm_ctrl.sv
module dsm_pwm_ctrl
  import dsm_pwm_pkg::*;
#(
  parameter int PWM_W = DEF_PWM_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loadStb,
  output ctlStrobes_t      ctl,
  output logic [PWM_W-1:0] pos
);

  localparam int PHASE_W = PWM_W + 1;

  logic [PHASE_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else     phase <= phase + 1'b1;
  end

  // rising half counts up, falling half mirrors it down
  always_comb begin
    pos = phase[PHASE_W-1] ? ~phase[PWM_W-1:0] : phase[PWM_W-1:0];
    ctl.periodEnd = &phase;
    ctl.loadNow   = loadStb;
  end

  // R1
  period_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.periodEnd |=> (pos == '0 && !ctl.periodEnd));

  // R1
  turn_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pos == {PWM_W{1'b1}} && !phase[PHASE_W-1]) |=> (pos == {PWM_W{1'b1}}));

endmodule

// File: rtl/dsm_pwm_chan.sv
module dsm_pwm_chan
  import dsm_pwm_pkg::*;
#(
  parameter int PWM_W  = DEF_PWM_W,
  parameter int FRAC_W = DEF_FRAC_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  ctlStrobes_t               ctl,
  input  logic [PWM_W-1:0]          pos,
  input  logic [PWM_W+FRAC_W-1:0]   levelIn,
  output logic                      pwmOut
);

  localparam int LVL_W = PWM_W + FRAC_W;
  localparam int CMP_W = PWM_W + 1;

  logic [LVL_W-1:0]  levelReg;
  logic [FRAC_W-1:0] acc;
  logic [CMP_W-1:0]  activeCmp;
  logic [CMP_W-1:0]  nextCmp;

  logic [PWM_W-1:0]  baseVal;
  logic [FRAC_W-1:0] fracVal;
  logic [FRAC_W:0]   accSum;
  logic [CMP_W-1:0]  nextCalc;
  logic [CMP_W-1:0]  loadCmp;

  always_comb begin
    baseVal  = levelReg[LVL_W-1:FRAC_W];
    fracVal  = levelReg[FRAC_W-1:0];
    accSum   = {1'b0, acc} + {1'b0, fracVal};
    nextCalc = {1'b0, baseVal} + CMP_W'(accSum[FRAC_W]);
    loadCmp  = {1'b0, levelIn[LVL_W-1:FRAC_W]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      levelReg  <= '0;
      acc       <= '0;
      activeCmp <= '0;
      nextCmp   <= '0;
      pwmOut    <= 1'b0;
    end else begin
      pwmOut <= ({1'b0, pos} < activeCmp);
      if (ctl.loadNow) begin
        levelReg  <= levelIn;
        activeCmp <= loadCmp;
        nextCmp   <= loadCmp;
      end else if (ctl.periodEnd) begin
        activeCmp <= nextCmp;
        acc       <= accSum[FRAC_W-1:0];
        nextCmp   <= nextCalc;
      end
    end
  end

  // R4
  cmp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl.loadNow && !ctl.periodEnd) |=> $stable(activeCmp));

  // R3
  cmp_range_chk: assert property (@(posedge clk) disable iff (rst)
    (activeCmp == {1'b0, baseVal}) || (activeCmp == {1'b0, baseVal} + 1'b1));

  // R6
  acc_keep_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.loadNow |=> $stable(acc));

  // R7
  zero_low_chk: assert property (@(posedge clk) disable iff (rst)
    (activeCmp == '0) |=> !pwmOut);

  // R8
  full_high_chk: assert property (@(posedge clk) disable iff (rst)
    (activeCmp[CMP_W-1]) |=> pwmOut);

endmodule

// File: rtl/dsm_pwm_datapath.sv
module dsm_pwm_datapath
  import dsm_pwm_pkg::*;
#(
  parameter int PWM_W    = DEF_PWM_W,
  parameter int FRAC_W   = DEF_FRAC_W,
  parameter int CH_COUNT = DEF_CH
) (
  input  logic                               clk,
  input  logic                               rst,
  input  ctlStrobes_t                        ctl,
  input  logic [PWM_W-1:0]                   pos,
  input  logic [CH_COUNT*(PWM_W+FRAC_W)-1:0] levelIn,
  output logic [CH_COUNT-1:0]                pwmOut
);

  localparam int LVL_W = PWM_W + FRAC_W;

  for (genvar ch = 0; ch < CH_COUNT; ch++) begin : g_chan
    dsm_pwm_chan #(
      .PWM_W  (PWM_W),
      .FRAC_W (FRAC_W)
    ) u_chan (
      .clk     (clk),
      .rst     (rst),
      .ctl     (ctl),
      .pos     (pos),
      .levelIn (levelIn[ch*LVL_W +: LVL_W]),
      .pwmOut  (pwmOut[ch])
    );
  end

endmodule

// File: rtl/dsm_pwm_top.sv
module dsm_pwm_top
  import dsm_pwm_pkg::*;
#(
  parameter int PWM_W    = DEF_PWM_W,
  parameter int FRAC_W   = DEF_FRAC_W,
  parameter int CH_COUNT = DEF_CH
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               loadStb,
  input  logic [CH_COUNT*(PWM_W+FRAC_W)-1:0] levelIn,
  output logic [CH_COUNT-1:0]                pwmOut
);

  ctlStrobes_t      ctl;
  logic [PWM_W-1:0] pos;

  dsm_pwm_ctrl #(
    .PWM_W (PWM_W)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .loadStb (loadStb),
    .ctl     (ctl),
    .pos     (pos)
  );

  dsm_pwm_datapath #(
    .PWM_W    (PWM_W),
    .FRAC_W   (FRAC_W),
    .CH_COUNT (CH_COUNT)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .pos     (pos),
    .levelIn (levelIn),
    .pwmOut  (pwmOut)
  );

endmodule

// File: tb/dsm_pwm_top_tb.sv
`timescale 1ns/1ps
module dsm_pwm_top_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        loadStb = 1'b0;
  logic [29:0] levelIn = '0;
  logic [1:0]  pwmOut;

  int checks = 0;
  int failures = 0;
  bit started = 1'b0;
  bit finished = 1'b0;
  int periodsDriven = 0;
  int periodsChecked = 0;

  typedef struct {
    int    cnt0;
    int    cnt1;
    string tag;
  } expItem_t;

  expItem_t expQ[$];

  // reference model state, one entry per channel
  int mActive[2];
  int mNext[2];
  int mAcc[2];
  int mLevel[2];

  always #2 clk = ~clk;

  dsm_pwm_top u_dut (
    .clk     (clk),
    .rst     (rst),
    .loadStb (loadStb),
    .levelIn (levelIn),
    .pwmOut  (pwmOut)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: computes the expected high counts of one period, then drives it
  task automatic runPeriod(input bit doLoad, input int j, input int la,
                           input int lb, input string tag);
    int newLv[2];
    expItem_t it;
    int cnt[2];
    newLv[0] = la;
    newLv[1] = lb;
    for (int ch = 0; ch < 2; ch++) begin
      cnt[ch] = 0;
      for (int k = 0; k < 512; k++) begin
        int p;
        int cu;
        p  = (k < 256) ? k : 511 - k;
        cu = (doLoad && k > j) ? (newLv[ch] >> 7) : mActive[ch];
        if (p < cu) cnt[ch]++;
      end
      if (doLoad) begin
        mLevel[ch]  = newLv[ch];
        mActive[ch] = newLv[ch] >> 7;
        mNext[ch]   = newLv[ch] >> 7;
      end
      if (!doLoad || j != 511) begin
        int sum;
        mActive[ch] = mNext[ch];
        sum         = mAcc[ch] + (mLevel[ch] & 127);
        mNext[ch]   = (mLevel[ch] >> 7) + ((sum > 127) ? 1 : 0);
        mAcc[ch]    = sum & 127;
      end
    end
    it.cnt0 = cnt[0];
    it.cnt1 = cnt[1];
    it.tag  = tag;
    expQ.push_back(it);
    periodsDriven++;
    for (int k = 0; k < 512; k++) begin
      if (doLoad && k == j) begin
        loadStb = 1'b1;
        levelIn = {lb[14:0], la[14:0]};
      end else begin
        loadStb = 1'b0;
      end
      @(negedge clk);
    end
    loadStb = 1'b0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) runPeriod(1'b0, 0, 0, 0, tag);
  endtask

  // monitor: counts high samples per period and compares with the queue
  initial begin
    wait (started);
    forever begin
      int c0;
      int c1;
      expItem_t it;
      c0 = 0;
      c1 = 0;
      for (int k = 0; k < 512; k++) begin
        @(posedge clk);
        #1;
        c0 += int'(pwmOut[0]);
        c1 += int'(pwmOut[1]);
      end
      if (expQ.size() == 0) begin
        chk("R1 unexpected period", 1, 0);
      end else begin
        it = expQ.pop_front();
        chk({it.tag, " ch0"}, c0, it.cnt0);
        chk({it.tag, " ch1"}, c1, it.cnt1);
      end
      periodsChecked++;
    end
  end

  initial begin
    for (int ch = 0; ch < 2; ch++) begin
      mActive[ch] = 0;
      mNext[ch]   = 0;
      mAcc[ch]    = 0;
      mLevel[ch]  = 0;
    end
    repeat (3) @(negedge clk);
    // R9 pins low in reset
    chk("R9 reset ch0", int'(pwmOut[0]), 0);
    chk("R9 reset ch1", int'(pwmOut[1]), 0);
    rst = 1'b0;
    started = 1'b1;

    idle(2, "R9 after reset");
    // R1 R2 plain coarse levels loaded on a boundary edge
    runPeriod(1'b1, 511, 100 << 7, 37 << 7, "R2 load");
    idle(3, "R1 steady");
    // R3 R4 fractional dithering
    runPeriod(1'b1, 511, (50 << 7) | 64, (200 << 7) | 127, "R3 load");
    idle(6, "R4 dither");
    // R5 mid-period load in rising half, accumulators keep residue
    runPeriod(1'b1, 100, (10 << 7) | 32, 180 << 7, "R5 rising load");
    idle(4, "R6 residue");
    // R5 mid-period load in falling half
    runPeriod(1'b1, 300, (240 << 7) | 5, (3 << 7) | 100, "R5 falling load");
    idle(3, "R3 after falling load");
    // R6 boundary load with nonzero accumulator, R8 full scale
    runPeriod(1'b1, 511, 32767, (255 << 7) | 1, "R6 boundary load");
    idle(5, "R8 full scale");
    // R7 zero both mid-period
    runPeriod(1'b1, 200, 0, 0, "R7 zero load");
    idle(3, "R7 zero steady");

    wait (periodsChecked == periodsDriven);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule